// File: doc/BRIEF.md
# Data EEPROM Register Controller

This block puts a 128-byte nonvolatile data store behind a small CPU register bus. Software programs an address register and a data register, then starts a transfer through a control register. Its start bits can be set by software but are cleared only by the hardware. A read loads the selected byte into the data register one cycle after it is started. A write is slow: it stays busy for a programmable number of clock cycles and stores the byte when that time has passed. It then raises a sticky completion interrupt.

Two guards protect against stray writes. The control register must have its write-enable bit set, and a two-key unlock sequence has to reach a storage-less unlock register on the two bus writes just before the start. A synchronous warm-reset input aborts any write in flight and leaves the stored byte untouched. It also clears the address and data registers and sets a sticky error bit that software can inspect afterwards.

The register offsets on `bus_addr_i` are: 0 address, 1 data, 2 control, 3 unlock, 4 interrupt flag. Offsets 5 to 7 are unmapped. Read data is combinational from `bus_addr_i`.

Top module: `data_nvm_ctrl`

## Requirements
- R1: Only bits 6:0 of the address register (offset 0) select the byte. Bit 7 is stored and reads back, but has no effect on which byte is accessed.
- R2: The control register (offset 2) holds the write-error flag in bit 3, write-enable in bit 2, write-start in bit 1 and read-start in bit 0. Bits 7:4 always read 0.
- R3: Writing 1 sets a start bit. Writing 0 to either start bit leaves it unchanged, so a running write keeps its start bit at 1.
- R4: A control write with bit 0 set makes read-start read 1 for exactly one cycle. On the next clock edge the addressed byte is in the data register and read-start reads 0.
- R5: An accepted write keeps write-start at 1 for WR_CYCLES cycles after the start edge. The byte is stored when that time ends, and write-start then reads 0.
- R6: A write is only accepted when the control write that sets bit 1 also has bit 2 (write-enable) at 1.
- R7: A write is only accepted when the two bus writes just before it were 8'h55 and then 8'hAA to the unlock register (offset 3). Any other bus access in between cancels the unlock.
- R8: If warm_rst_i is high while a write is busy, the write is aborted and the stored byte is unchanged. The error bit sets and stays 1 until software writes a 0 to bit 3. The address and data registers read 0 after any warm reset.
- R9: The unlock register and offsets 5 to 7 always read 8'h00.
- R10: The interrupt flag (offset 4 bit 0, also on done_irq_o) sets when a write completes. It stays set until software writes 0 to offset 4 bit 0.
- R11: A read-start written while a write is busy is ignored: read-start stays 0 and the data register is unchanged.
- R12: After rst_ni the address, data, control and interrupt registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| warm_rst_i | input | 1 | Synchronous warm reset, aborts a busy write |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe (used for unlock cancel) |
| bus_rdata_o | output | 8 | Combinational read data |
| done_irq_o | output | 1 | Sticky write-complete interrupt |

## Verification
Register writes take effect at the edge that captures the strobe. The bench drives on falling edges and samples half a cycle later, after that edge. Read-start is seen for one cycle, and the fetched byte is checked one falling edge after the control write. Write-start is checked to be still high WR_CYCLES-1 cycles after the start write and low one cycle later. The interrupt flag and the stored byte are checked at that same point. Warm-reset effects are checked one cycle after the pulse, and the byte it protects is read back through a normal read.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;
  localparam int unsigned BUS_AW = 3;

  typedef enum logic [BUS_AW-1:0] {
    OFS_ADDR   = 3'd0,
    OFS_DATA   = 3'd1,
    OFS_CTRL   = 3'd2,
    OFS_UNLOCK = 3'd3,
    OFS_IRQ    = 3'd4
  } reg_ofs_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_KEY1  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_st_e;

  localparam int unsigned CB_ERR = 3;
  localparam int unsigned CB_WEN = 2;
  localparam int unsigned CB_WR  = 1;
  localparam int unsigned CB_RD  = 0;
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
  import nvm_ctrl_pkg::*;
#(
  parameter logic [7:0] KEY1 = 8'h55,
  parameter logic [7:0] KEY2 = 8'hAA
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       we_i,
  input  logic       re_i,
  input  logic       sel_i,
  input  logic [7:0] wdata_i,
  output logic       armed_o
);
  unlock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (clr_i)                                          st_d = UL_IDLE;
    else if (we_i && sel_i && wdata_i == KEY1)          st_d = UL_KEY1;
    else if (we_i && sel_i && wdata_i == KEY2 && st_q == UL_KEY1) st_d = UL_ARMED;
    else if (we_i || re_i)                              st_d = UL_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= UL_IDLE;
    else         st_q <= st_d;
  end

  assign armed_o = (st_q == UL_ARMED);
endmodule

// File: rtl/nvm_wr_timer.sv
module nvm_wr_timer #(
  parameter int unsigned WR_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = (WR_CYCLES < 2) ? 1 : $clog2(WR_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign done_o = busy_q && (cnt_q == '0) && !abort_i;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/data_nvm_ctrl.sv
module data_nvm_ctrl
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_BITS = 7,
  parameter int unsigned WR_CYCLES = 16,
  parameter logic [7:0]  KEY1      = 8'h55,
  parameter logic [7:0]  KEY2      = 8'hAA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warm_rst_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [7:0]       bus_wdata_i,
  input  logic             bus_we_i,
  input  logic             bus_re_i,
  output logic [7:0]       bus_rdata_o,
  output logic             done_irq_o
);
  logic sel_addr, sel_data, sel_ctrl, sel_unlock, sel_irq;
  logic ctrl_wr, start_wr, start_rd;
  logic armed, wr_busy, wr_done;
  logic [7:0] addr_q, data_q;
  logic wren_q, err_q, rd_q, irq_q;
  logic [ADDR_BITS-1:0] lat_addr_q;
  logic [7:0] lat_data_q, arr_rdata;

  assign sel_addr   = bus_addr_i == OFS_ADDR;
  assign sel_data   = bus_addr_i == OFS_DATA;
  assign sel_ctrl   = bus_addr_i == OFS_CTRL;
  assign sel_unlock = bus_addr_i == OFS_UNLOCK;
  assign sel_irq    = bus_addr_i == OFS_IRQ;

  assign ctrl_wr  = bus_we_i && sel_ctrl;
  assign start_wr = ctrl_wr && bus_wdata_i[CB_WR] && bus_wdata_i[CB_WEN]
                    && armed && !wr_busy && !warm_rst_i;
  assign start_rd = ctrl_wr && bus_wdata_i[CB_RD] && !wr_busy && !start_wr
                    && !rd_q && !warm_rst_i;

  nvm_unlock #(.KEY1(KEY1), .KEY2(KEY2)) u_unlock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (warm_rst_i),
    .we_i    (bus_we_i),
    .re_i    (bus_re_i),
    .sel_i   (sel_unlock),
    .wdata_i (bus_wdata_i),
    .armed_o (armed)
  );

  nvm_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_wr),
    .abort_i (warm_rst_i),
    .busy_o  (wr_busy),
    .done_o  (wr_done)
  );

  nvm_array #(.AW(ADDR_BITS), .DW(8)) u_array (
    .clk_i   (clk_i),
    .we_i    (wr_done),
    .waddr_i (lat_addr_q),
    .wdata_i (lat_data_q),
    .raddr_i (addr_q[ADDR_BITS-1:0]),
    .rdata_o (arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (warm_rst_i) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (bus_we_i && sel_addr) addr_q <= bus_wdata_i;
      if (rd_q)                        data_q <= arr_rdata;
      else if (bus_we_i && sel_data)   data_q <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wren_q <= 1'b0;
      rd_q   <= 1'b0;
      err_q  <= 1'b0;
    end else if (warm_rst_i) begin
      wren_q <= 1'b0;
      rd_q   <= 1'b0;
      if (wr_busy) err_q <= 1'b1;
    end else begin
      rd_q <= start_rd;
      if (ctrl_wr) begin
        wren_q <= bus_wdata_i[CB_WEN];
        if (!bus_wdata_i[CB_ERR]) err_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_addr_q <= '0;
      lat_data_q <= '0;
    end else if (start_wr) begin
      lat_addr_q <= addr_q[ADDR_BITS-1:0];
      lat_data_q <= data_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   irq_q <= 1'b0;
    else if (wr_done)                              irq_q <= 1'b1;
    else if (bus_we_i && sel_irq && !bus_wdata_i[0]) irq_q <= 1'b0;
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFS_ADDR: bus_rdata_o = addr_q;
      OFS_DATA: bus_rdata_o = data_q;
      OFS_CTRL: bus_rdata_o = {4'b0000, err_q, wren_q, wr_busy, rd_q};
      OFS_IRQ:  bus_rdata_o = {7'b0, irq_q};
      default:  bus_rdata_o = '0;
    endcase
  end

  assign done_irq_o = irq_q;
endmodule

// File: rtl/data_nvm_ctrl_chk.sv
module data_nvm_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       warm_rst_i,
  input logic [2:0] bus_addr_i,
  input logic [7:0] bus_wdata_i,
  input logic [7:0] bus_rdata_o,
  input logic       done_irq_o,
  input logic       armed,
  input logic       wr_busy,
  input logic       wr_done,
  input logic       rd_q,
  input logic       err_q
);
  assert_rd_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |=> !rd_q);

  assert_wr_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_busy && !wr_done && !warm_rst_i) |=> wr_busy);

  assert_wr_needs_unlock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_busy) |-> $past(armed));

  assert_wr_needs_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_busy) |-> $past(bus_wdata_i[2]));

  assert_err_from_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(warm_rst_i && wr_busy));

  assert_ctrl_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == 3'd2) |-> (bus_rdata_o[7:4] == 4'h0));

  assert_unlock_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == 3'd3) |-> (bus_rdata_o == 8'h00));

  assert_irq_from_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_irq_o) |-> $past(wr_done));

  assert_no_rd_while_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_q) |-> !$past(wr_busy));
endmodule

bind data_nvm_ctrl data_nvm_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .warm_rst_i  (warm_rst_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .done_irq_o  (done_irq_o),
  .armed       (armed),
  .wr_busy     (wr_busy),
  .wr_done     (wr_done),
  .rd_q        (rd_q),
  .err_q       (err_q)
);

// File: tb/sim_data_nvm_ctrl.sv
module sim_data_nvm_ctrl;
  localparam int unsigned W = 16;
  localparam logic [2:0] A_ADDR = 3'd0, A_DATA = 3'd1, A_CTRL = 3'd2,
                         A_UNL = 3'd3, A_IRQ = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic warm = 1'b0;
  logic [2:0] baddr = '0;
  logic [7:0] bwdata = '0;
  logic bwe = 1'b0, bre = 1'b0;
  logic [7:0] brdata;
  logic irq;
  int vec = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  data_nvm_ctrl #(.WR_CYCLES(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_i(warm),
    .bus_addr_i(baddr), .bus_wdata_i(bwdata), .bus_we_i(bwe), .bus_re_i(bre),
    .bus_rdata_o(brdata), .done_irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); baddr = a; bwdata = d; bwe = 1'b1;
    @(negedge clk); bwe = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    baddr = a; #1; d = brdata;
  endtask

  task automatic rd_strobe(input logic [2:0] a);
    @(negedge clk); baddr = a; bre = 1'b1;
    @(negedge clk); bre = 1'b0;
  endtask

  task automatic start_write(input logic [7:0] a, input logic [7:0] d);
    wr(A_ADDR, a); wr(A_DATA, d); wr(A_UNL, 8'h55); wr(A_UNL, 8'hAA); wr(A_CTRL, 8'h06);
  endtask

  task automatic read_byte(input logic [7:0] a, output logic [7:0] d);
    wr(A_ADDR, a); wr(A_CTRL, 8'h01);
    @(negedge clk); peek(A_DATA, d);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    peek(A_ADDR, v); chk("R12 addr", v, 8'h00);
    peek(A_DATA, v); chk("R12 data", v, 8'h00);
    peek(A_CTRL, v); chk("R12 ctrl", v, 8'h00);
    peek(A_IRQ, v);  chk("R12 irq", v, 8'h00);
  endtask

  task automatic t_write_read;
    logic [7:0] v;
    start_write(8'h05, 8'h3C);
    peek(A_CTRL, v); chk("R5 wr set", v, 8'h06);
    repeat (W-1) @(negedge clk);
    peek(A_CTRL, v); chk("R5 wr held", v, 8'h06);
    @(negedge clk);
    peek(A_CTRL, v); chk("R5 wr clear", v, 8'h04);
    chk("R10 irq set", {7'b0, irq}, 8'h01);
    wr(A_CTRL, 8'h01);
    peek(A_CTRL, v); chk("R4 rd visible", v, 8'h01);
    @(negedge clk);
    peek(A_CTRL, v); chk("R4 rd cleared", v, 8'h00);
    peek(A_DATA, v); chk("R4 data loaded", v, 8'h3C);
  endtask

  task automatic t_irq_sticky;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    peek(A_IRQ, v); chk("R10 irq sticky", v, 8'h01);
    wr(A_IRQ, 8'h00);
    peek(A_IRQ, v); chk("R10 irq cleared", v, 8'h00);
  endtask

  task automatic t_no_wren;
    logic [7:0] v;
    wr(A_ADDR, 8'h05); wr(A_DATA, 8'h99);
    wr(A_UNL, 8'h55); wr(A_UNL, 8'hAA); wr(A_CTRL, 8'h02);
    peek(A_CTRL, v); chk("R6 no start", v, 8'h00);
    repeat (W+2) @(negedge clk);
    read_byte(8'h05, v); chk("R6 byte kept", v, 8'h3C);
  endtask

  task automatic t_bad_unlock;
    logic [7:0] v;
    wr(A_ADDR, 8'h05); wr(A_DATA, 8'h99);
    wr(A_UNL, 8'h55); wr(A_DATA, 8'h99); wr(A_UNL, 8'hAA); wr(A_CTRL, 8'h06);
    peek(A_CTRL, v); chk("R7 broken by write", v, 8'h04);
    wr(A_UNL, 8'h55); rd_strobe(A_ADDR); wr(A_UNL, 8'hAA); wr(A_CTRL, 8'h06);
    peek(A_CTRL, v); chk("R7 broken by read", v, 8'h04);
    wr(A_UNL, 8'hAA); wr(A_UNL, 8'h55); wr(A_CTRL, 8'h06);
    peek(A_CTRL, v); chk("R7 wrong order", v, 8'h04);
    repeat (W+2) @(negedge clk);
    read_byte(8'h05, v); chk("R7 byte kept", v, 8'h3C);
  endtask

  task automatic t_set_only;
    logic [7:0] v;
    start_write(8'h06, 8'hA5);
    @(negedge clk);
    wr(A_CTRL, 8'h04);
    peek(A_CTRL, v); chk("R3 wr not cleared", v, 8'h06);
    wr(A_DATA, 8'h11);
    wr(A_CTRL, 8'h05);
    peek(A_CTRL, v); chk("R11 rd ignored", v, 8'h06);
    @(negedge clk);
    peek(A_DATA, v); chk("R11 data unchanged", v, 8'h11);
    repeat (W) @(negedge clk);
    peek(A_CTRL, v); chk("R3 wr done by hw", v, 8'h04);
    read_byte(8'h06, v); chk("R5 latched data", v, 8'hA5);
    wr(A_IRQ, 8'h00);
  endtask

  task automatic t_addr_msb;
    logic [7:0] v;
    read_byte(8'h85, v); chk("R1 msb ignored", v, 8'h3C);
    peek(A_ADDR, v); chk("R1 msb stored", v, 8'h85);
  endtask

  task automatic t_warm_abort;
    logic [7:0] v;
    start_write(8'h05, 8'h77);
    repeat (3) @(negedge clk);
    warm = 1'b1;
    @(negedge clk); warm = 1'b0;
    peek(A_CTRL, v); chk("R8 err set", v, 8'h08);
    peek(A_ADDR, v); chk("R8 addr cleared", v, 8'h00);
    peek(A_DATA, v); chk("R8 data cleared", v, 8'h00);
    repeat (W+2) @(negedge clk);
    chk("R8 no irq", {7'b0, irq}, 8'h00);
    wr(A_ADDR, 8'h05); wr(A_CTRL, 8'h09);
    @(negedge clk);
    peek(A_DATA, v); chk("R8 byte kept", v, 8'h3C);
    peek(A_CTRL, v); chk("R8 err sticky", v, 8'h08);
    wr(A_CTRL, 8'h00);
    peek(A_CTRL, v); chk("R8 err cleared", v, 8'h00);
  endtask

  task automatic t_zero_regs;
    logic [7:0] v;
    wr(A_UNL, 8'h5A);
    peek(A_UNL, v); chk("R9 unlock zero", v, 8'h00);
    peek(3'd6, v);  chk("R9 unmapped zero", v, 8'h00);
    wr(A_CTRL, 8'hF4);
    peek(A_CTRL, v); chk("R2 upper zero", v, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_irq_sticky();
    t_no_wren();
    t_bad_unlock();
    t_set_only();
    t_addr_msb();
    t_warm_abort();
    t_zero_regs();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vec++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule